// File: doc/BRIEF.md
# DMA Remapping Address Translator

This block sits between I/O devices and memory and vets each DMA request before it reaches the memory system. A request carries a 16-bit requester identity, a device-side (guest-physical) address and a byte count. The identity selects a context entry. The entry either assigns the device to one of the domains or marks it as unassigned.

Each domain sees memory as a window that starts at guest address zero and is a whole number of 4 KB pages long. The window is relocated to a host page base. The translator either returns the relocated host address or reports a fault. A fault carries a reason code, the requester identity and the original guest address.

A one-entry context cache keeps the most recent identity-to-domain resolution. Back-to-back requests from the same device therefore skip the table read. Configuration software fills the context and domain tables through two write strobes. Any table write empties the cache.

Top module: `dma_remap_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and every context entry is absent, so any request faults with reason 1.
- R2: The requester identity is laid out as bus in bits [15:8], device in bits [7:3] and function in bits [2:0]. The context entry is chosen by identity bits [4:0]. The entry applies only when its stored 16-bit identity equals the request's identity; otherwise the response is a fault with reason 1.
- R3: A request that hits an entry whose present flag is clear faults with reason 1 (not present). Reason 1 takes priority over every other reason.
- R4: A legal request returns `rsp_fault`=0, `rsp_reason`=0 and `rsp_addr` = domain base page × 4096 + guest address.
- R5: A request is legal only when guest address + length − 1 < domain size in pages × 4096. This sum is computed without wrap-around. An illegal request faults with reason 2 (out of range).
- R6: A request with length 0 from an assigned device faults with reason 3.
- R7: When the identity matches the cached entry, the response appears in the cycle after acceptance. On a cache miss, the response appears one cycle later than that.
- R8: A write to either table invalidates the context cache. The next request from any device then takes miss latency and sees the new table contents.
- R9: `req_ready` is low from acceptance until the response cycle. `rsp_valid` is high for exactly one cycle per accepted request.
- R10: A faulting response presents the request's identity on `rsp_rid` and the guest address, zero-extended, on `rsp_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_rid | input | 16 | Requester identity (bus, device, function) |
| req_addr | input | GPA_W | Guest-physical start address |
| req_len | input | LEN_W | Transfer length in bytes |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_fault | output | 1 | Request blocked |
| rsp_reason | output | 2 | 0 ok, 1 not present, 2 out of range, 3 zero length |
| rsp_rid | output | 16 | Identity of the answered request |
| rsp_addr | output | HPA_W | Host address, or guest address on fault |
| ctx_we | input | 1 | Context table write strobe |
| ctx_idx | input | log2(CTX_N) | Context entry to write |
| ctx_present | input | 1 | Entry assigned flag |
| ctx_rid | input | 16 | Full identity stored for compare |
| ctx_dom | input | log2(DOM_N) | Domain assigned to the device |
| dom_we | input | 1 | Domain table write strobe |
| dom_idx | input | log2(DOM_N) | Domain to write |
| dom_pages | input | SZ_W | Window size in 4 KB pages |
| dom_base | input | HPA_W-12 | Host base page number |

## Verification
The bench builds the translator with its default parameters: 32-bit guest addresses, 40-bit host addresses, 16-bit lengths and 20-bit page counts. It uses 32 context entries and 16 domains. With these values, a domain can be given the largest possible window, 0xFFFFF pages, which ends just below the 4 GB guest limit. A request near the top of guest space can then carry its end address past bit 31, where a wrapping comparator would wrongly pass it. The 40-bit host width lets a base above 4 GB show that the relocation adds with full carry.

// File: rtl/dma_remap_xlate.sv
module dma_remap_xlate #(
  parameter int GPA_W = 32,
  parameter int HPA_W = 40,
  parameter int LEN_W = 16,
  parameter int SZ_W  = 20,
  parameter int CTX_N = 32,
  parameter int DOM_N = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [15:0]            req_rid,
  input  logic [GPA_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]       req_len,
  output logic                   rsp_valid,
  output logic                   rsp_fault,
  output logic [1:0]             rsp_reason,
  output logic [15:0]            rsp_rid,
  output logic [HPA_W-1:0]       rsp_addr,
  input  logic                   ctx_we,
  input  logic [$clog2(CTX_N)-1:0] ctx_idx,
  input  logic                   ctx_present,
  input  logic [15:0]            ctx_rid,
  input  logic [$clog2(DOM_N)-1:0] ctx_dom,
  input  logic                   dom_we,
  input  logic [$clog2(DOM_N)-1:0] dom_idx,
  input  logic [SZ_W-1:0]        dom_pages,
  input  logic [HPA_W-13:0]      dom_base
);
  localparam int IDX_W = $clog2(CTX_N);
  localparam int DOM_W = $clog2(DOM_N);
  localparam int PG_W  = HPA_W - 12;
  localparam int EW    = ((GPA_W > SZ_W + 12) ? GPA_W : SZ_W + 12) + 2;
  localparam logic [1:0] RS_OK = 2'd0, RS_ABSENT = 2'd1, RS_RANGE = 2'd2, RS_ZERO = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_EVAL} st_t;
  st_t st;

  logic             ctx_tbl_pres [CTX_N];
  logic [15:0]      ctx_tbl_rid  [CTX_N];
  logic [DOM_W-1:0] ctx_tbl_dom  [CTX_N];
  logic [SZ_W-1:0]  dom_tbl_pages [DOM_N];
  logic [PG_W-1:0]  dom_tbl_base  [DOM_N];

  logic             cache_vld, cache_ok;
  logic [15:0]      cache_rid;
  logic [DOM_W-1:0] cache_dom;

  logic [15:0]      s_rid;
  logic [GPA_W-1:0] s_addr;
  logic [LEN_W-1:0] s_len;

  wire any_we = ctx_we | dom_we;
  wire accept = req_valid & req_ready;
  wire hit    = cache_vld & ~any_we & (cache_rid == req_rid);
  wire [IDX_W-1:0] fidx = s_rid[IDX_W-1:0];

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_EVAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CTX_N; i++) begin
        ctx_tbl_pres[i] <= 1'b0;
        ctx_tbl_rid[i]  <= '0;
        ctx_tbl_dom[i]  <= '0;
      end
      for (int i = 0; i < DOM_N; i++) begin
        dom_tbl_pages[i] <= '0;
        dom_tbl_base[i]  <= '0;
      end
    end else begin
      if (ctx_we) begin
        ctx_tbl_pres[ctx_idx] <= ctx_present;
        ctx_tbl_rid[ctx_idx]  <= ctx_rid;
        ctx_tbl_dom[ctx_idx]  <= ctx_dom;
      end
      if (dom_we) begin
        dom_tbl_pages[dom_idx] <= dom_pages;
        dom_tbl_base[dom_idx]  <= dom_base;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      s_rid     <= '0;
      s_addr    <= '0;
      s_len     <= '0;
      cache_vld <= 1'b0;
      cache_ok  <= 1'b0;
      cache_rid <= '0;
      cache_dom <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          s_rid  <= req_rid;
          s_addr <= req_addr;
          s_len  <= req_len;
          st     <= hit ? ST_EVAL : ST_FILL;
        end
        ST_FILL: begin
          cache_rid <= s_rid;
          cache_ok  <= ctx_tbl_pres[fidx] & (ctx_tbl_rid[fidx] == s_rid);
          cache_dom <= ctx_tbl_dom[fidx];
          cache_vld <= 1'b1;
          st        <= ST_EVAL;
        end
        default: st <= ST_IDLE;
      endcase
      if (any_we) cache_vld <= 1'b0;
    end
  end

  wire [EW-1:0] last_byte = EW'(s_addr) + EW'(s_len) - EW'(1);
  wire [EW-1:0] win_limit = EW'({dom_tbl_pages[cache_dom], 12'h000});
  wire [HPA_W-1:0] host_a = {dom_tbl_base[cache_dom], 12'h000} + HPA_W'(s_addr);

  always_comb begin
    if (!cache_ok)                rsp_reason = RS_ABSENT;
    else if (s_len == '0)         rsp_reason = RS_ZERO;
    else if (last_byte >= win_limit) rsp_reason = RS_RANGE;
    else                          rsp_reason = RS_OK;
  end

  assign rsp_fault = (rsp_reason != RS_OK);
  assign rsp_rid   = s_rid;
  assign rsp_addr  = rsp_fault ? HPA_W'(s_addr) : host_a;

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R7
  hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> rsp_valid);
  // R7
  miss_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> !rsp_valid);
  // R8
  inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_we |=> !cache_vld);
  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && s_len == '0) |-> rsp_fault);
endmodule

// File: tb/tb_dma_remap_xlate.sv
module tb_dma_remap_xlate;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [15:0] req_rid = 0;
  logic [31:0] req_addr = 0;
  logic [15:0] req_len = 0;
  logic rsp_valid, rsp_fault;
  logic [1:0] rsp_reason;
  logic [15:0] rsp_rid;
  logic [39:0] rsp_addr;
  logic ctx_we = 0, ctx_present = 0;
  logic [4:0] ctx_idx = 0;
  logic [15:0] ctx_rid = 0;
  logic [3:0] ctx_dom = 0;
  logic dom_we = 0;
  logic [3:0] dom_idx = 0;
  logic [19:0] dom_pages = 0;
  logic [27:0] dom_base = 0;

  int nchk = 0, nerr = 0;

  dma_remap_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rid(req_rid), .req_addr(req_addr), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_reason(rsp_reason),
    .rsp_rid(rsp_rid), .rsp_addr(rsp_addr),
    .ctx_we(ctx_we), .ctx_idx(ctx_idx), .ctx_present(ctx_present),
    .ctx_rid(ctx_rid), .ctx_dom(ctx_dom),
    .dom_we(dom_we), .dom_idx(dom_idx), .dom_pages(dom_pages), .dom_base(dom_base));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wctx(input logic [4:0] idx, input logic pres, input logic [15:0] rid, input logic [3:0] dom);
    @(negedge clk);
    ctx_we = 1; ctx_idx = idx; ctx_present = pres; ctx_rid = rid; ctx_dom = dom;
    @(negedge clk);
    ctx_we = 0;
  endtask

  task automatic wdom(input logic [3:0] idx, input logic [19:0] pages, input logic [27:0] base);
    @(negedge clk);
    dom_we = 1; dom_idx = idx; dom_pages = pages; dom_base = base;
    @(negedge clk);
    dom_we = 0;
  endtask

  task automatic send(input logic [15:0] rid, input logic [31:0] addr, input logic [15:0] len,
                      input logic [1:0] exp_rs, input logic [39:0] exp_a, input int exp_lat,
                      input string req);
    int lat;
    @(negedge clk);
    req_valid = 1; req_rid = rid; req_addr = addr; req_len = len;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    if (!rsp_valid) chk(req_ready == 0, {req, " R9 stall ready"}, 64'(req_ready), 64'd0);
    while (!rsp_valid && lat < 4) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, {req, " R7 latency"}, 64'(lat), 64'(exp_lat));
    chk(rsp_reason == exp_rs && rsp_fault == (exp_rs != 0), {req, " reason"}, 64'(rsp_reason), 64'(exp_rs));
    chk(rsp_addr == exp_a, {req, " address"}, 64'(rsp_addr), 64'(exp_a));
    chk(rsp_rid == rid, {req, " R10 rid"}, 64'(rsp_rid), 64'(rid));
    @(negedge clk);
    chk(rsp_valid == 0, {req, " R9 single pulse"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    send(16'h0108, 32'h2000, 16'h10, 2'd1, 40'h2000, 2, "R1 empty table");
  endtask

  task automatic t_translate;
    wdom(4'd3, 20'd16, 28'h12345);
    wctx(5'd11, 1'b1, 16'h1A2B, 4'd3);
    send(16'h1A2B, 32'h3000, 16'h100, 2'd0, 40'h12348000, 2, "R4 first miss");
    send(16'h1A2B, 32'h0FF0, 16'h10, 2'd0, 40'h12345FF0, 1, "R4 R7 hit");
  endtask

  task automatic t_range;
    send(16'h1A2B, 32'hF000, 16'h1000, 2'd0, 40'h12354000, 1, "R5 last byte in window");
    send(16'h1A2B, 32'hF000, 16'h1001, 2'd2, 40'hF000, 1, "R5 one byte over");
    send(16'h1A2B, 32'h0, 16'h0, 2'd3, 40'h0, 1, "R6 zero length");
  endtask

  task automatic t_alias;
    send(16'h002B, 32'h100, 16'h4, 2'd1, 40'h100, 2, "R2 index alias, other bus");
    send(16'h002B, 32'h100, 16'h0, 2'd1, 40'h100, 1, "R3 absent beats zero length");
    send(16'h1A2B, 32'h100, 16'h4, 2'd0, 40'h12345100, 2, "R2 owner after alias");
  endtask

  task automatic t_inval;
    wdom(4'd4, 20'd1, 28'h00AB0);
    wctx(5'd11, 1'b1, 16'h1A2B, 4'd4);
    send(16'h1A2B, 32'h10, 16'h4, 2'd0, 40'hAB0010, 2, "R8 remap after write");
    send(16'h1A2B, 32'h1000, 16'h1, 2'd2, 40'h1000, 1, "R8 R5 new window size");
    wdom(4'd4, 20'd2, 28'h00AB0);
    send(16'h1A2B, 32'h1000, 16'h1, 2'd0, 40'hAB1000, 2, "R8 domain write invalidates");
    wctx(5'd11, 1'b0, 16'h1A2B, 4'd4);
    send(16'h1A2B, 32'h10, 16'h4, 2'd1, 40'h10, 2, "R3 cleared present flag");
  endtask

  task automatic t_top;
    wdom(4'd5, 20'hFFFFF, 28'h1000000);
    wctx(5'd7, 1'b1, 16'h0307, 4'd5);
    send(16'h0307, 32'hFFFFE000, 16'h1000, 2'd0, 40'h10FFFFE000, 2, "R4 R5 top of window");
    send(16'h0307, 32'hFFFFF000, 16'h2000, 2'd2, 40'hFFFFF000, 1, "R5 no wrap past 4GB");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_translate;
    t_range;
    t_alias;
    t_inval;
    t_top;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule